// File: doc/BRIEF.md
# Preset-Reload Programmable Frequency Divider

This block divides its clock by a programmable modulus. Four 4-bit synchronous counter stages are chained into one 16-bit up-counter. Each stage passes its carry to the next through a ripple-carry enable, so a stage advances only when every stage below it is at its all-ones value. When the whole counter reaches all ones, the carry out of the top stage forces a synchronous parallel load of the preset into every stage on the next clock. The counter therefore visits 65536 − P states for a preset P.

To divide by N, the preset is set to 65536 − N. For example, 0x8AD0 gives a modulus of 30,000 and 0x63C0 gives 40,000, which turns 5 MHz into 125 Hz. A preset of zero lets the counter run through all 65,536 states. The divided output is a registered pulse, one clock wide, that rises once per modulus cycle in the cycle right after the reload.

Top module: `preset_divider`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `count` takes the value on `preset` and `div_pulse` goes low.
- R2: With `en` high and `count` not 0xFFFF, `count` increases by exactly one on each clock.
- R3: With `en` low and `count` not 0xFFFF, `count` holds its value.
- R4: When `count` is 0xFFFF, the next clock loads the value present on `preset` at that edge. This happens whether `en` is high or low.
- R5: With `en` held high, rising edges of `div_pulse` come every 65536 − P clocks for preset P. A preset of 0 gives 65536 clocks.
- R6: `div_pulse` is high for exactly the one cycle that follows a reload, during which `count` equals the preset just loaded. The exception is preset 0xFFFF (divide by one), where it stays high.
- R7: A change on `preset` between reloads does not alter `count`. It takes effect at the next reload.
- R8: A stage advances only when all lower stages read 0xF. So 0x00FF steps to 0x0100 and 0x0FFF steps to 0x1000, with no stage moving early.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock being divided |
| rst_n | input | 1 | Synchronous active-low reset; loads the preset |
| en | input | 1 | Count enable applied to every stage |
| preset | input | 16 | Reload value, equal to 65536 minus the modulus |
| count | output | 16 | Current counter value |
| div_pulse | output | 1 | One-clock divided output pulse |

## Verification
A table of presets drives the period measurement. It covers the extremes: divide by one, divide by two, and the full 65,536-state run. A design with an off-by-one reload would show each period one clock long or short. A design that only reloaded on overflow to zero would break the divide-by-one case. Directed tests cover the carry crossing nibble boundaries, where a carry chain wired without gating would advance upper stages too early. They also cover holding with `en` low at the terminal value, which a design that gates the load with the enable would get wrong by sticking at 0xFFFF. A preset changed mid-cycle is checked as well: a design that loads continuously would jump to the new value at once.

// File: rtl/fdiv_pkg.sv
// Shared definitions for the preset-reload divider.
// Assumes every stage has the same width.
package fdiv_pkg;
    localparam int NIB_W = 4;

    // Per-stage control bundle: count enable, carry enable, active-low load.
    typedef struct packed {
        logic enp;
        logic ent;
        logic load_n;
    } stage_ctl_t;
endpackage

// File: rtl/fdiv_stage.sv
// One synchronous binary counter stage with parallel load.
// Load wins over counting; counting needs both enp and ent.
// rco flags all-ones gated by ent, feeding the next stage's ent.
// Assumes synchronous active-low reset that loads d.
module fdiv_stage
    import fdiv_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  stage_ctl_t   ctl,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         rco
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    // Stage register: reset/load take d, else count when fully enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctl.load_n)
            q <= d;
        else if (ctl.enp && ctl.ent)
            q <= q + 1'b1;
    end

    // Carry out: terminal value of this stage while carry-in is present.
    always_comb rco = ctl.ent && (q == ALL_ONES);

    // R8: without carry-in and without load, the stage must not move.
    p_stage_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.load_n && !ctl.ent) |=> $stable(q));
endmodule

// File: rtl/fdiv_tick.sv
// Registers the terminal-count flag into the divided output pulse.
// Assumes term is high for one cycle per modulus period.
module fdiv_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic term,
    output logic pulse
);
    // Pulse register: one clock after terminal count, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= term;
    end
endmodule

// File: rtl/preset_divider.sv
// Programmable divider: STAGES cascaded counter stages chained by
// carry enables; top-stage carry reloads every stage with the preset.
// Assumes preset = 2**CNT_W - N for modulus N.
module preset_divider
    import fdiv_pkg::*;
#(
    parameter  int STAGES  = 4,
    parameter  int STAGE_W = NIB_W,
    localparam int CNT_W   = STAGES * STAGE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] count,
    output logic             div_pulse
);
    localparam logic [CNT_W-1:0] TERM_VAL = {CNT_W{1'b1}};

    logic [STAGES:0] carry;
    logic            reload_n;

    // Carry chain origin: lowest stage always sees carry-in.
    always_comb carry[0] = 1'b1;
    // Reload strobe: inverted carry out of the top stage.
    always_comb reload_n = ~carry[STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        stage_ctl_t ctl;
        // Stage control: shared enable, chained carry, shared reload.
        always_comb begin
            ctl.enp    = en;
            ctl.ent    = carry[g];
            ctl.load_n = reload_n;
        end
        fdiv_stage #(.W(STAGE_W)) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .ctl  (ctl),
            .d    (preset[g*STAGE_W +: STAGE_W]),
            .q    (count[g*STAGE_W +: STAGE_W]),
            .rco  (carry[g+1])
        );
    end

    fdiv_tick u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .term (carry[STAGES]),
        .pulse(div_pulse)
    );

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count != TERM_VAL) |=> count == CNT_W'($past(count) + 1'b1));

    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && count != TERM_VAL) |=> $stable(count));

    p_reload_preset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TERM_VAL) |=> count == $past(preset));

    p_pulse_at_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> count == $past(preset));
endmodule

// File: tb/test_preset_divider.sv
module test_preset_divider;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic [15:0] pre;
        logic [16:0] period;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{16'hFFFF, 17'd1},
        '{16'hFFFE, 17'd2},
        '{16'hFFFB, 17'd5},
        '{16'hFFF0, 17'd16},
        '{16'hFF00, 17'd256},
        '{16'hEC78, 17'd5000},
        '{16'h0000, 17'd65536}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] preset = 16'h0;
    logic [15:0] count;
    logic        div_pulse;
    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    preset_divider i_preset_divider (
        .clk(clk), .rst_n(rst_n), .en(en), .preset(preset),
        .count(count), .div_pulse(div_pulse)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [15:0] p);
        preset = p;
        rst_n  = 1'b0;
        en     = 1'b0;
        tick();
        rst_n  = 1'b1;
    endtask

    initial begin
        #(CLK_P * 195000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        tick();
        // R5 and R6: walk preset table, measure pulse spacing
        for (int i = 0; i < NV; i++) begin
            int n;
            do_reset(VECS[i].pre);
            en = 1'b1;
            n = 0;
            while (!div_pulse && n < 70000) begin tick(); n++; end
            chk(count == VECS[i].pre, "R6 count at pulse", count, VECS[i].pre);
            n = 0;
            do begin tick(); n++; end while (!div_pulse && n < 70000);
            chk(n == int'(VECS[i].period), "R5 period", n, VECS[i].period);
        end

        // R1: reset loads preset, pulse low
        do_reset(16'h1234);
        chk(count == 16'h1234, "R1 reset count", count, 16'h1234);
        chk(div_pulse == 1'b0, "R1 reset pulse", div_pulse, 0);
        // R3: hold with en low
        tick(); tick(); tick();
        chk(count == 16'h1234, "R3 hold", count, 16'h1234);
        // R2: single step
        en = 1'b1; tick();
        chk(count == 16'h1235, "R2 step", count, 16'h1235);

        // R8: carry crossing nibble boundaries
        do_reset(16'h00FF); en = 1'b1; tick();
        chk(count == 16'h0100, "R8 carry 00FF", count, 16'h0100);
        do_reset(16'h0FFF); en = 1'b1; tick();
        chk(count == 16'h1000, "R8 carry 0FFF", count, 16'h1000);
        do_reset(16'h0FEF); en = 1'b1; tick();
        chk(count == 16'h0FF0, "R8 carry 0FEF", count, 16'h0FF0);

        // R4: reload at terminal with en low
        do_reset(16'hFFFE); en = 1'b1; tick();
        chk(count == 16'hFFFF, "R2 reach terminal", count, 16'hFFFF);
        en = 1'b0; tick();
        chk(count == 16'hFFFE, "R4 reload en low", count, 16'hFFFE);
        chk(div_pulse == 1'b1, "R6 pulse after reload", div_pulse, 1);
        tick();
        chk(count == 16'hFFFE, "R3 hold after reload", count, 16'hFFFE);
        chk(div_pulse == 1'b0, "R6 pulse one wide", div_pulse, 0);

        // R7: preset change takes effect only at reload
        do_reset(16'hFFF0); en = 1'b1; tick(); tick(); tick();
        preset = 16'hFFF8; tick();
        chk(count == 16'hFFF4, "R7 no early load", count, 16'hFFF4);
        while (count != 16'hFFFF) tick();
        tick();
        chk(count == 16'hFFF8, "R7 new preset at reload", count, 16'hFFF8);

        // R6: divide by one keeps pulse high
        do_reset(16'hFFFF); en = 1'b1; tick(); tick();
        chk(div_pulse == 1'b1, "R6 div1 pulse", div_pulse, 1);
        tick();
        chk(div_pulse == 1'b1 && count == 16'hFFFF, "R6 div1 steady", count, 16'hFFFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule